// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes a single PWM waveform and distributes it to up to four output pins, labelled A, B, C and D. For each pin a control bit decides whether it carries the waveform, with a polarity chosen by a two-bit selection, or falls back to a general-purpose port value. A one-byte control register is written through a simple write strobe and can be read back.

New steering settings can take effect on the next clock edge. They can also be parked in a shadow copy and moved into the live setting on the next period-boundary strobe from the PWM timebase, so a pin never changes role in the middle of a PWM period. An alternating mode hands the waveform between pins A and B on every period boundary, while C and D keep following their own enable bits.

Steering applies only while the PWM is configured for single-output operation, which is signalled on a dedicated input. In any other configuration every pin passes its port value through unchanged.

Top module: `pwm_steer`

## Requirements
- R1: After a synchronous reset the control byte reads 8'h01, and only pin A carries the waveform.
- R2: Control bits [3:0] enable pins A (bit 0), B (bit 1), C (bit 2) and D (bit 3). An enabled pin carries the waveform and a disabled pin drives its bit of `port_val`.
- R3: `pol_sel` sets the polarity of a steered pin. 2'b00 makes every pin active-high. 2'b01 makes A and C active-high and B and D active-low. 2'b10 makes A and C active-low and B and D active-high. 2'b11 makes every pin active-low. An active-low pin drives the inverse of `pwm_in`.
- R4: A write with control bit 4 clear changes the pins starting in the cycle that follows the write edge.
- R5: A write with control bit 4 set leaves the pins unchanged until the next `period_stb` edge. A second such write before that strobe replaces the pending value.
- R6: When control bit 6 is 1, pins A and B alternate. A carries the waveform first, and ownership swaps on each `period_stb`. The pin that does not own the waveform drives its inactive polarity level, not the port value. Bit 7 is stored and read back but has no effect.
- R7: While `steer_ok` is 0, `pin_out` equals `port_val`, and the A/B alternation restarts from pin A.
- R8: Control bit 5 always reads 0, whatever value is written to it. `rd_data` returns the most recently written byte with bit 5 cleared.
- R9: A deferred write in the same cycle as `period_stb` does not take effect on that strobe. The strobe applies the previously pending value, and the new value waits for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM waveform to be steered |
| period_stb | input | 1 | One-cycle pulse at each PWM period boundary |
| pol_sel | input | 2 | Polarity selection (R3) |
| steer_ok | input | 1 | High when the PWM is in single-output PWM configuration |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read value |
| port_val | input | 4 | Port values for pins A..D (bit 0 = A) |
| pin_out | output | 4 | Pin drive for A..D (bit 0 = A) |

## Verification
The hardest case to reach is a deferred write landing in the same cycle as a period strobe, with a second write following before the next strobe. In that case the shadow and live settings hold three distinct values across two boundaries. The stimulus creates this case on purpose with distinct enable patterns, so each stage is visible on the pins. It then runs a long pseudo-random phase that mixes writes, strobes, polarity and configuration changes while alternation is active. The behavioural model is compared after every clock.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    localparam int NPINS  = 4;
    localparam int CTRL_W = 8;
    localparam int SYNC_BIT = 4;

    typedef struct packed {
        logic [1:0]       alt_fld;  // bit 6 enables A/B alternation
        logic             rsv;      // always zero
        logic             sync;     // 1 = defer to period strobe
        logic [NPINS-1:0] en;       // bit 0 = pin A
    } steer_ctrl_t;

    localparam steer_ctrl_t CTRL_RST = '{alt_fld: 2'b00, rsv: 1'b0, sync: 1'b0, en: 4'b0001};

    typedef enum logic [1:0] {
        POL_ALL_HI = 2'b00,
        POL_BD_LO  = 2'b01,
        POL_AC_LO  = 2'b10,
        POL_ALL_LO = 2'b11
    } pol_e;

    // Per-pin inversion mask: bit set means the pin is active-low.
    function automatic logic [NPINS-1:0] inv_mask(input pol_e p);
        case (p)
            POL_ALL_HI: inv_mask = 4'b0000;
            POL_BD_LO:  inv_mask = 4'b1010;
            POL_AC_LO:  inv_mask = 4'b0101;
            default:    inv_mask = 4'b1111;
        endcase
    endfunction

    function automatic steer_ctrl_t sanitize(input logic [CTRL_W-1:0] d);
        steer_ctrl_t c;
        c     = steer_ctrl_t'(d);
        c.rsv = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs
    import pwm_steer_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         period_stb,
    output steer_ctrl_t  shadow_q,
    output steer_ctrl_t  active_q
);

    steer_ctrl_t wr_ctrl;

    always_comb wr_ctrl = sanitize(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= CTRL_RST;
            active_q <= CTRL_RST;
        end else begin
            if (period_stb)
                active_q <= shadow_q;
            if (wr_en) begin
                shadow_q <= wr_ctrl;
                if (!wr_ctrl.sync)
                    active_q <= wr_ctrl;
            end
        end
    end

endmodule

// File: rtl/pwm_steer_alt.sv
module pwm_steer_alt (
    input  logic clk,
    input  logic rst,
    input  logic steer_ok,
    input  logic alt_on,
    input  logic period_stb,
    output logic alt_b
);

    always_ff @(posedge clk) begin
        if (rst || !steer_ok || !alt_on)
            alt_b <= 1'b0;
        else if (period_stb)
            alt_b <= ~alt_b;
    end

endmodule

// File: rtl/pwm_steer_mux.sv
module pwm_steer_mux #(
    parameter int NP = 4
) (
    input  logic          pwm_in,
    input  logic [NP-1:0] inv,
    input  logic [NP-1:0] en,
    input  logic [NP-1:0] port_val,
    input  logic          steer_ok,
    input  logic          alt_on,
    input  logic          alt_b,
    output logic [NP-1:0] pin_out
);

    for (genvar i = 0; i < NP; i++) begin : g_pin
        logic drive;
        assign drive = pwm_in ^ inv[i];
        if (i < 2) begin : g_pair
            logic owns;
            assign owns = (i == 0) ? ~alt_b : alt_b;
            always_comb begin
                if (!steer_ok)   pin_out[i] = port_val[i];
                else if (alt_on) pin_out[i] = owns ? drive : inv[i];
                else             pin_out[i] = en[i] ? drive : port_val[i];
            end
        end else begin : g_plain
            always_comb begin
                if (!steer_ok) pin_out[i] = port_val[i];
                else           pin_out[i] = en[i] ? drive : port_val[i];
            end
        end
    end

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
    import pwm_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_in,
    input  logic              period_stb,
    input  logic [1:0]        pol_sel,
    input  logic              steer_ok,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic [NPINS-1:0]  port_val,
    output logic [NPINS-1:0]  pin_out
);

    steer_ctrl_t      shadow_q;
    steer_ctrl_t      active_q;
    logic             alt_b;
    logic [NPINS-1:0] inv;

    assign inv     = inv_mask(pol_e'(pol_sel));
    assign rd_data = shadow_q;

    pwm_steer_regs #(.W(CTRL_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .period_stb (period_stb),
        .shadow_q   (shadow_q),
        .active_q   (active_q)
    );

    pwm_steer_alt u_alt (
        .clk        (clk),
        .rst        (rst),
        .steer_ok   (steer_ok),
        .alt_on     (active_q.alt_fld[0]),
        .period_stb (period_stb),
        .alt_b      (alt_b)
    );

    pwm_steer_mux #(.NP(NPINS)) u_mux (
        .pwm_in   (pwm_in),
        .inv      (inv),
        .en       (active_q.en),
        .port_val (port_val),
        .steer_ok (steer_ok),
        .alt_on   (active_q.alt_fld[0]),
        .alt_b    (alt_b),
        .pin_out  (pin_out)
    );

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       period_stb,
    input logic       steer_ok,
    input logic [3:0] port_val,
    input logic [3:0] pin_out,
    input logic [7:0] rd_data,
    input logic [7:0] act,
    input logic       alt_b
);

    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rd_data == 8'h01);

    p_port_fallback_r7: assert property (@(posedge clk) disable iff (rst)
        !steer_ok |-> pin_out == port_val);

    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (rst)
        rd_data[5] == 1'b0);

    p_immediate_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(wr_en) && !$past(wr_data[4]) |-> act == ($past(wr_data) & 8'hDF));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(wr_en) && !$past(period_stb) |-> $stable(act));

    p_alt_steady_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(period_stb) && $past(steer_ok && act[6]) && steer_ok && act[6]
        |-> $stable(alt_b));

    p_alt_flip_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(period_stb && steer_ok && act[6]) && steer_ok && act[6]
        |-> alt_b != $past(alt_b));

endmodule

bind pwm_steer pwm_steer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .period_stb (period_stb),
    .steer_ok   (steer_ok),
    .port_val   (port_val),
    .pin_out    (pin_out),
    .rd_data    (rd_data),
    .act        (active_q),
    .alt_b      (alt_b)
);

// File: tb/pwm_steer_tb.sv
module pwm_steer_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic       period_stb = 1'b0;
    logic [1:0] pol_sel = 2'b00;
    logic       steer_ok = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] port_val = 4'h0;
    logic [3:0] pin_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic [7:0] m_sh, m_act;
    logic       m_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_steer u_dut (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .period_stb(period_stb),
        .pol_sel(pol_sel), .steer_ok(steer_ok), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .port_val(port_val), .pin_out(pin_out)
    );

    function automatic logic [3:0] exp_pins();
        logic [3:0] iv, r;
        case (pol_sel)
            2'b00: iv = 4'b0000;
            2'b01: iv = 4'b1010;
            2'b10: iv = 4'b0101;
            default: iv = 4'b1111;
        endcase
        for (int i = 0; i < 4; i++) begin
            if (!steer_ok) r[i] = port_val[i];
            else if (m_act[6] && i < 2) begin
                bit own = (i == 0) ? !m_sel : m_sel;
                r[i] = own ? (pwm_in ^ iv[i]) : iv[i];
            end else r[i] = m_act[i] ? (pwm_in ^ iv[i]) : port_val[i];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        logic [7:0] nsh, nact;
        logic       nsel;
        @(posedge clk);
        if (rst) begin
            m_sh = 8'h01; m_act = 8'h01; m_sel = 1'b0;
        end else begin
            nsel = (!steer_ok || !m_act[6]) ? 1'b0 : (period_stb ? ~m_sel : m_sel);
            nsh = m_sh; nact = m_act;
            if (period_stb) nact = m_sh;
            if (wr_en) begin
                nsh = wr_data & 8'hDF;
                if (!wr_data[4]) nact = nsh;
            end
            m_sh = nsh; m_act = nact; m_sel = nsel;
        end
        @(negedge clk);
        check({tag, " pins"}, {4'h0, pin_out}, {4'h0, exp_pins()});
        check({tag, " rd"}, rd_data, m_sh);
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_data = d;
        tick(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        m_sh = 8'h01; m_act = 8'h01; m_sel = 1'b0;
        repeat (3) tick("R1");
        rst = 1'b0;
        steer_ok = 1'b1; pwm_in = 1'b1; port_val = 4'b0000;
        tick("R1");
        check("R1 reset byte", rd_data, 8'h01);
        check("R1 only A", {4'h0, pin_out}, 8'h01);

        // R2 / R3: every enable pattern under every polarity and pwm level
        for (int e = 0; e < 16; e++) begin
            wr(8'(e), "R2");
            for (int p = 0; p < 4; p++) begin
                for (int w = 0; w < 2; w++) begin
                    pol_sel = 2'(p); pwm_in = w[0]; port_val = ~4'(e) ^ 4'(p);
                    tick("R3");
                end
            end
        end
        pol_sel = 2'b01; pwm_in = 1'b1; port_val = 4'b0000; wr(8'h0F, "R3");
        check("R3 BD low", {4'h0, pin_out}, 8'h05);

        // R8: reserved bit
        pol_sel = 2'b00;
        wr(8'h2F, "R8");
        check("R8 rsv read", rd_data, 8'h0F);

        // R4: immediate update
        port_val = 4'b0000; pwm_in = 1'b1;
        wr(8'h03, "R4");
        check("R4 next cycle", {4'h0, pin_out}, 8'h03);

        // R5: deferred update, replaced before strobe
        wr(8'h14, "R5");
        check("R5 held", {4'h0, pin_out}, 8'h03);
        repeat (3) tick("R5");
        wr(8'h18, "R5");
        tick("R5");
        check("R5 still held", {4'h0, pin_out}, 8'h03);
        period_stb = 1'b1; tick("R5"); period_stb = 1'b0;
        check("R5 replaced value", {4'h0, pin_out}, 8'h08);

        // R9: deferred write coincident with strobe
        wr(8'h12, "R9");
        period_stb = 1'b1; wr(8'h11, "R9"); period_stb = 1'b0;
        check("R9 old pending applied", {4'h0, pin_out}, 8'h02);
        tick("R9");
        period_stb = 1'b1; tick("R9"); period_stb = 1'b0;
        check("R9 new applied", {4'h0, pin_out}, 8'h01);

        // R6: alternation over several periods
        wr(8'hCC, "R6");
        check("R6 A first", {4'h0, pin_out}, 8'h0D);
        for (int k = 0; k < 8; k++) begin
            pol_sel = 2'(k);
            for (int c = 0; c < 6; c++) begin
                pwm_in = c[0]; period_stb = (c == 5); tick("R6");
            end
            period_stb = 1'b0;
        end
        pol_sel = 2'b00; pwm_in = 1'b1;
        period_stb = 1'b1; tick("R6"); period_stb = 1'b0;
        check("R6 B owns", {4'h0, pin_out}, 8'h0E);

        // R7: steering gated off
        steer_ok = 1'b0; port_val = 4'b0110; tick("R7");
        check("R7 port", {4'h0, pin_out}, 8'h06);
        steer_ok = 1'b1; port_val = 4'b0000; tick("R7");
        check("R7 restart A", {4'h0, pin_out}, 8'h0D);

        // Mixed pseudo-random phase: R2,R3,R5,R6,R7,R9
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pwm_in     = lfsr[0];
            period_stb = (lfsr[4:2] == 3'b000);
            pol_sel    = lfsr[6:5];
            steer_ok   = (lfsr[11:9] != 3'b000);
            port_val   = lfsr[15:12];
            wr_en      = (lfsr[8:7] == 2'b00) && lfsr[1];
            wr_data    = {lfsr[3], lfsr[14], lfsr[2], lfsr[9], lfsr[13:10]};
            tick("R6 mix");
        end
        wr_en = 1'b0; period_stb = 1'b0;
        tick("R5 mix");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule